// File: doc/BRIEF.md
# I2C Slave Receiver Byte Sequencer

This block is the receive half of an interrupt-driven I2C slave. It watches already filtered SCL and SDA levels together with single-cycle START and STOP detect pulses. After a START it shifts in an address byte, most significant bit first. The byte is compared with a programmable 7-bit own address and, when enabled, with the all-zero general-call address. If recognition is allowed, the block pulls SDA low for the acknowledge. It then goes on to take in data bytes.

Each protocol event ends in a fixed 8-bit status code and a raised interrupt flag. While the flag is set the block holds SCL low, so the bus master waits. Software reads the status and the received byte, changes the acknowledge control bit if it wants to, and then clears the flag with a strobe. The strobe takes effect only while a separate qualifier input is high. The acknowledge decision for a byte is taken from the acknowledge control bit at the start of that byte's acknowledge slot.

Top module: `i2csr_slave_rx`

## Requirements
- R1: A synchronous reset (rst high) leaves irq low, scl_low low, sda_low low and status at F8h, the no-information code.
- R2: An address byte whose bits [7:1] equal addr_reg[7:1] and whose bit 0 (direction) is 0 is acknowledged while aa is 1. SDA is pulled low during the ninth SCL pulse, and afterwards status becomes 60h with irq high.
- R3: The address byte 00h is acknowledged and gives status 70h only when addr_reg[0] is 1 and aa is 1. When addr_reg[0] is 0 it gets no acknowledge and no interrupt.
- R4: With aa at 0 no address is acknowledged and no interrupt is raised. An own-address byte with direction bit 1 is ignored the same way, and so is any non-matching address.
- R5: Data bytes shift in MSB first and appear on rx_data when the interrupt rises. When addressed by own address the status is 80h if the byte was acknowledged and 88h if not. When addressed by general call it is 90h or 98h.
- R6: status[2:0] are always 0, and every code raised with the interrupt is one of the codes above or A0h or 00h, never F8h.
- R7: While irq is high, scl_low is high and irq stays high. Only si_clr with clr_en high clears it. si_clr alone has no effect. Clearing returns status to F8h and releases SCL.
- R8: After a non-acknowledged data byte (88h or 98h) the block is no longer addressed. Further bytes of that transfer get no acknowledge and raise no interrupt.
- R9: A STOP or repeated START seen while addressed gives status A0h. After a repeated START the next address byte is recognised again.
- R10: A START or STOP seen while the block itself drives the acknowledge gives status 00h (bus error). SDA is released at once and the block becomes not addressed.
- R11: The acknowledge of a data byte follows the value of aa at the start of its acknowledge slot, so a change of aa in the middle of the byte applies to that byte's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Filtered SCL line level |
| sda_in | input | 1 | Filtered SDA line level |
| start_det | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_det | input | 1 | One-cycle pulse: STOP seen |
| addr_reg | input | 8 | Own address in [7:1], general-call enable in [0] |
| aa | input | 1 | Assert-acknowledge control bit |
| si_clr | input | 1 | Software strobe to clear the interrupt flag |
| clr_en | input | 1 | Qualifier that must be high for si_clr to act |
| scl_low | output | 1 | Pull SCL low (clock stretch while interrupt pending) |
| sda_low | output | 1 | Pull SDA low (acknowledge) |
| status | output | 8 | Status code, 5-bit code in [7:3], [2:0] zero |
| rx_data | output | 8 | Last completed byte |
| irq | output | 1 | Interrupt request, high while flag set |

## Verification
SCL edges are found by a register inside the block. The acknowledge pull-down therefore appears on the first clock after the block sees the SCL fall that ends the eighth bit. Interrupt, status and rx_data change on the first clock after the block sees the fall that ends the ninth pulse. A boundary pulse or a qualified clear strobe acts on the very next clock. The bench holds every SCL phase for four clocks. It samples the acknowledge halfway through the ninth high phase, and it reads status, irq and rx_data four clocks after the closing fall, so each check falls well after the result is due and before the next input changes.

// File: rtl/i2csr_pkg.sv
package i2csr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,   // not addressed
    SR_ADDR = 2'd1,   // collecting address byte
    SR_DATA = 2'd2    // addressed, collecting data bytes
  } sr_state_t;

  localparam logic [7:0] CODE_OWN_ADDR = 8'h60;
  localparam logic [7:0] CODE_GC_ADDR  = 8'h70;
  localparam logic [7:0] CODE_OWN_ACK  = 8'h80;
  localparam logic [7:0] CODE_OWN_NAK  = 8'h88;
  localparam logic [7:0] CODE_GC_ACK   = 8'h90;
  localparam logic [7:0] CODE_GC_NAK   = 8'h98;
  localparam logic [7:0] CODE_BOUNDARY = 8'hA0;
  localparam logic [7:0] CODE_NO_INFO  = 8'hF8;
  localparam logic [7:0] CODE_BUS_ERR  = 8'h00;

  // own address with write direction
  function automatic logic own_hit(input logic [7:0] rx, input logic [7:0] areg);
    return (rx[7:1] == areg[7:1]) && !rx[0];
  endfunction

  // general call, only when enabled in bit 0 of the address register
  function automatic logic gc_hit(input logic [7:0] rx, input logic [7:0] areg);
    return (rx == 8'h00) && areg[0];
  endfunction

  function automatic logic [7:0] data_code(input logic gc, input logic acked);
    case ({gc, acked})
      2'b01:   return CODE_OWN_ACK;
      2'b00:   return CODE_OWN_NAK;
      2'b11:   return CODE_GC_ACK;
      default: return CODE_GC_NAK;
    endcase
  endfunction
endpackage

// File: rtl/i2csr_edge.sv
module i2csr_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic rise,
  output logic fall
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line_in;
  end

  assign rise = line_in & ~line_q;
  assign fall = ~line_in & line_q;
endmodule

// File: rtl/i2csr_shift.sv
module i2csr_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hold,
  input  logic          rise,
  input  logic          sda,
  output logic [W-1:0]  shreg,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = CW'(W + 1);
  localparam logic [CW-1:0] CNT_BYTE = CW'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (!hold && rise && cnt != CNT_MAX) begin
      if (cnt < CNT_BYTE) shreg <= {shreg[W-2:0], sda};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2csr_ctrl.sv
module i2csr_ctrl
  import i2csr_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  shreg,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    addr_reg,
  input  logic          aa,
  input  logic          si_clr,
  input  logic          clr_en,
  output logic          cnt_clr,
  output logic          si,
  output logic          sda_low,
  output logic [7:0]    status,
  output logic [W-1:0]  rx_data
);
  localparam logic [CW-1:0] SLOT_OPEN = CW'(W);
  localparam logic [CW-1:0] SLOT_DONE = CW'(W + 1);

  sr_state_t state;
  logic gc_mode, acked, pend;

  // named events for the checks below
  logic clr_ok, boundary, open_slot, close_slot;
  assign clr_ok     = si_clr & clr_en;
  assign boundary   = start_det | stop_det;
  assign open_slot  = fall && (cnt == SLOT_OPEN);
  assign close_slot = fall && (cnt == SLOT_DONE);
  assign cnt_clr    = !si && (boundary || close_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SR_IDLE;
      si      <= 1'b0;
      sda_low <= 1'b0;
      status  <= CODE_NO_INFO;
      rx_data <= '0;
      gc_mode <= 1'b0;
      acked   <= 1'b0;
      pend    <= 1'b0;
    end else if (si) begin
      if (clr_ok) begin
        si     <= 1'b0;
        status <= CODE_NO_INFO;
      end
    end else if (boundary) begin
      pend <= 1'b0;
      if (sda_low) begin
        sda_low <= 1'b0;
        si      <= 1'b1;
        status  <= CODE_BUS_ERR;
        state   <= SR_IDLE;
      end else if (state == SR_DATA) begin
        si     <= 1'b1;
        status <= CODE_BOUNDARY;
        state  <= start_det ? SR_ADDR : SR_IDLE;
      end else begin
        state <= start_det ? SR_ADDR : SR_IDLE;
      end
    end else if (open_slot) begin
      if (state == SR_ADDR) begin
        rx_data <= shreg;
        if (aa && own_hit(shreg[7:0], addr_reg)) begin
          sda_low <= 1'b1;
          acked   <= 1'b1;
          pend    <= 1'b1;
          gc_mode <= 1'b0;
        end else if (aa && gc_hit(shreg[7:0], addr_reg)) begin
          sda_low <= 1'b1;
          acked   <= 1'b1;
          pend    <= 1'b1;
          gc_mode <= 1'b1;
        end else begin
          state <= SR_IDLE;
        end
      end else if (state == SR_DATA) begin
        rx_data <= shreg;
        sda_low <= aa;
        acked   <= aa;
        pend    <= 1'b1;
      end
    end else if (close_slot && pend) begin
      pend    <= 1'b0;
      sda_low <= 1'b0;
      si      <= 1'b1;
      if (state == SR_ADDR) begin
        status <= gc_mode ? CODE_GC_ADDR : CODE_OWN_ADDR;
        state  <= SR_DATA;
      end else begin
        status <= data_code(gc_mode, acked);
        if (!acked) state <= SR_IDLE;
      end
    end
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (si && !clr_ok) |=> si);
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(si) |-> ($past(clr_ok) && status == CODE_NO_INFO));
  // R4
  ack_needs_aa_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> $past(aa));
  // R6
  raised_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(si) |-> (status[2:0] == 3'b000 && status != CODE_NO_INFO));
  // R10
  ack_not_during_irq_chk: assert property (@(posedge clk) disable iff (rst)
    sda_low |-> !si);
endmodule

// File: rtl/i2csr_slave_rx.sv
module i2csr_slave_rx
  import i2csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] addr_reg,
  input  logic       aa,
  input  logic       si_clr,
  input  logic       clr_en,
  output logic       scl_low,
  output logic       sda_low,
  output logic [7:0] status,
  output logic [7:0] rx_data,
  output logic       irq
);
  localparam int CW = $clog2(BYTE_W + 2);

  logic scl_rise, scl_fall, cnt_clr, si;
  logic [CW-1:0] cnt;
  logic [BYTE_W-1:0] shreg;

  i2csr_edge u_edge (
    .clk(clk), .rst(rst), .line_in(scl_in), .rise(scl_rise), .fall(scl_fall)
  );

  i2csr_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clr(cnt_clr), .hold(si), .rise(scl_rise),
    .sda(sda_in), .shreg(shreg), .cnt(cnt)
  );

  i2csr_ctrl #(.W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .fall(scl_fall), .cnt(cnt), .shreg(shreg),
    .start_det(start_det), .stop_det(stop_det), .addr_reg(addr_reg),
    .aa(aa), .si_clr(si_clr), .clr_en(clr_en), .cnt_clr(cnt_clr),
    .si(si), .sda_low(sda_low), .status(status), .rx_data(rx_data)
  );

  assign irq     = si;
  assign scl_low = si;
endmodule

// File: tb/i2csr_slave_rx_test.sv
module i2csr_slave_rx_test;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0;
  logic [7:0] addr_reg = 8'h75;
  logic aa = 1'b1, si_clr = 1'b0, clr_en = 1'b0;
  logic scl_low, sda_low, irq;
  logic [7:0] status, rx_data;
  logic scl_in, sda_in;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  assign scl_in = m_scl & ~scl_low;
  assign sda_in = m_sda & ~sda_low;

  i2csr_slave_rx uut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .addr_reg(addr_reg),
    .aa(aa), .si_clr(si_clr), .clr_en(clr_en), .scl_low(scl_low),
    .sda_low(sda_low), .status(status), .rx_data(rx_data), .irq(irq)
  );

  function automatic logic [7:0] exp_addr(input logic [7:0] b, input logic [7:0] areg,
                                          input logic a);
    if (!a) return 8'hFF;
    if (b[0] == 1'b0 && b[7:1] == areg[7:1]) return 8'h60;
    if (b == 8'h00 && areg[0]) return 8'h70;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_data(input logic gc, input logic a);
    return 8'h80 | (gc ? 8'h10 : 8'h00) | (a ? 8'h00 : 8'h08);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_scl;
    int n = 0;
    while (!scl_in && n < 2000) begin tick(1); n++; end
    if (n >= 2000) chk("R7 stretch timeout", 8'd1, 8'd0);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; m_scl = 1'b1; tick(H);
    m_sda = 1'b0; start_det = 1'b1; tick(1); start_det = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; stop_det = 1'b1; tick(1); stop_det = 1'b0; tick(H);
  endtask

  // flip_bit: bit index at which aa is changed (-1 none); err_ack: pulse STOP in ack slot
  task automatic send_byte(input logic [7:0] b, input int flip_bit, input logic flip_val,
                           input logic err_ack, output logic acked);
    acked = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      if (i == flip_bit) aa = flip_val;
      m_scl = 1'b1; wait_scl(); tick(H);
      m_scl = 1'b0; tick(H);
    end
    m_sda = 1'b1; tick(H);
    if (err_ack) begin
      acked = ~sda_in;
      stop_det = 1'b1; tick(1); stop_det = 1'b0; tick(H);
      return;
    end
    m_scl = 1'b1; wait_scl(); tick(H/2);
    acked = ~sda_in;
    tick(H/2);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic service(input string tag, input logic [7:0] code);
    chk({tag, " irq"}, {7'd0, irq}, 8'd1);
    chk({tag, " status"}, status, code);
    chk("R6 low bits", {5'd0, status[2:0]}, 8'd0);
    chk("R7 scl held", {7'd0, scl_low}, 8'd1);
    si_clr = 1'b1; clr_en = 1'b1; tick(1);
    si_clr = 1'b0; clr_en = 1'b0; tick(2);
    chk("R7 cleared irq", {7'd0, irq}, 8'd0);
    chk("R7 cleared status", status, 8'hF8);
    chk("R7 scl released", {7'd0, scl_low}, 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d, code;
    void'($urandom(32'd4242));
    tick(3);
    rst = 1'b0; tick(1);
    // R1
    chk("R1 status", status, 8'hF8);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 scl_low", {7'd0, scl_low}, 8'd0);
    chk("R1 sda_low", {7'd0, sda_low}, 8'd0);

    // R2 own address, R7 unqualified clear ignored
    addr_reg = {7'h3A, 1'b1}; aa = 1'b1;
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    chk("R2 ack", {7'd0, ack}, 8'd1);
    si_clr = 1'b1; tick(1); si_clr = 1'b0; tick(2);
    chk("R7 clear without qualifier", {7'd0, irq}, 8'd1);
    chk("R7 line held", {7'd0, scl_in}, 8'd0);
    service("R2", 8'h60);

    // R5 acked data byte, MSB first
    send_byte(8'hA5, -1, 1'b0, 1'b0, ack);
    chk("R5 ack", {7'd0, ack}, 8'd1);
    chk("R5 rx_data", rx_data, 8'hA5);
    service("R5", 8'h80);

    // R11 aa dropped mid-byte applies at this byte's slot
    send_byte(8'h1E, 3, 1'b0, 1'b0, ack);
    chk("R11 nack", {7'd0, ack}, 8'd0);
    chk("R5 rx_data 2", rx_data, 8'h1E);
    service("R11", 8'h88);

    // R8 no longer addressed
    aa = 1'b1;
    send_byte(8'h55, -1, 1'b0, 1'b0, ack);
    chk("R8 no ack", {7'd0, ack}, 8'd0);
    chk("R8 no irq", {7'd0, irq}, 8'd0);
    bus_stop();
    chk("R8 stop ignored", {7'd0, irq}, 8'd0);

    // R3 general call enabled
    bus_start();
    send_byte(8'h00, -1, 1'b0, 1'b0, ack);
    chk("R3 gc ack", {7'd0, ack}, 8'd1);
    service("R3", 8'h70);
    send_byte(8'h3C, -1, 1'b0, 1'b0, ack);
    service("R5 gc ack", 8'h90);
    aa = 1'b0;
    send_byte(8'hC3, -1, 1'b0, 1'b0, ack);
    chk("R5 gc nack", {7'd0, ack}, 8'd0);
    service("R5 gc", 8'h98);
    aa = 1'b1;
    bus_stop();

    // R3 general call disabled
    addr_reg = {7'h3A, 1'b0};
    bus_start();
    send_byte(8'h00, -1, 1'b0, 1'b0, ack);
    chk("R3 gc off ack", {7'd0, ack}, 8'd0);
    chk("R3 gc off irq", {7'd0, irq}, 8'd0);
    bus_stop();

    // R4 aa=0, read direction, foreign address
    aa = 1'b0;
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    chk("R4 aa0 ack", {7'd0, ack}, 8'd0);
    chk("R4 aa0 irq", {7'd0, irq}, 8'd0);
    aa = 1'b1;
    bus_start();
    send_byte({7'h3A, 1'b1}, -1, 1'b0, 1'b0, ack);
    chk("R4 read dir ack", {7'd0, ack}, 8'd0);
    chk("R4 read dir irq", {7'd0, irq}, 8'd0);
    bus_start();
    send_byte(8'h20, -1, 1'b0, 1'b0, ack);
    chk("R4 foreign ack", {7'd0, ack}, 8'd0);
    chk("R4 foreign irq", {7'd0, irq}, 8'd0);
    bus_stop();

    // R9 stop and repeated start while addressed
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    service("R9 addr", 8'h60);
    send_byte(8'h77, -1, 1'b0, 1'b0, ack);
    service("R9 data", 8'h80);
    bus_stop();
    service("R9 stop", 8'hA0);
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    service("R9 addr2", 8'h60);
    bus_start();
    service("R9 restart", 8'hA0);
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    chk("R9 readdressed ack", {7'd0, ack}, 8'd1);
    service("R9 readdressed", 8'h60);
    bus_stop();
    service("R9 stop2", 8'hA0);

    // R10 bus error during own acknowledge
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b1, ack);
    chk("R10 was driving ack", {7'd0, ack}, 8'd1);
    chk("R10 sda released", {7'd0, sda_low}, 8'd0);
    service("R10", 8'h00);
    send_byte({7'h3A, 1'b0}, -1, 1'b0, 1'b0, ack);
    chk("R10 not addressed", {7'd0, ack}, 8'd0);
    chk("R10 no irq", {7'd0, irq}, 8'd0);
    bus_stop();

    // random transfers
    for (int t = 0; t < 16; t++) begin
      logic [6:0] own;
      logic ended;
      own = 7'(($urandom % 127) + 1);
      addr_reg = {own, 1'($urandom)};
      aa = 1'b1;
      bus_start();
      d = {own, 1'b0};
      send_byte(d, -1, 1'b0, 1'b0, ack);
      code = exp_addr(d, addr_reg, 1'b1);
      chk("R2 rnd ack", {7'd0, ack}, 8'd1);
      service("R2 rnd", code);
      ended = 1'b0;
      for (int k = 0; k < 4 && !ended; k++) begin
        d = 8'($urandom);
        aa = 1'($urandom);
        code = exp_data(1'b0, aa);
        send_byte(d, -1, 1'b0, 1'b0, ack);
        chk("R5 rnd ack", {7'd0, ack}, {7'd0, aa});
        chk("R5 rnd rx_data", rx_data, d);
        service("R5 rnd", code);
        if (!aa) ended = 1'b1;
      end
      bus_stop();
      if (ended) chk("R8 rnd stop ignored", {7'd0, irq}, 8'd0);
      else service("R9 rnd stop", 8'hA0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule